// File: doc/BRIEF.md
# Multi-format PCM serial receiver

This block turns a stereo PCM bit stream into parallel sample words. It runs entirely on the bit clock. On each rising edge it samples the word-select (frame) clock and the serial data line. A 2-bit format input picks one of four justification schemes, each with 48 bit periods per frame (24 per channel half). The block presents a 24-bit left word, a 24-bit right word and a single-cycle strobe for every complete stereo frame. Samples are MSB-first two's-complement.

The receiver only commits a half-frame once the frame clock toggles again. A half-frame is kept only if it spans exactly 24 bit periods. Halves that are too short or too long are discarded, together with any pending left word. The stream therefore locks back onto the next regular frame without further action.

Top module: `pcm_serial_rx`

## Requirements
- R1: While `rst` is high at a rising edge, `valid_o`, `left_o` and `right_o` become 0 after that edge.
- R2: With `fmt_i` = 2'b10 (24-bit left-justified), `lrck_i` high marks left and low marks right. The word is the 24 bits sampled in the half's bit periods 0..23, MSB in period 0, where period 0 is the first rising edge at which the new `lrck_i` level is seen.
- R3: With `fmt_i` = 2'b11 (I2S), `lrck_i` low marks left and high marks right. The MSB sits in period 1 of the half and bit 1 in period 23. The LSB is taken in period 0 of the following half.
- R4: With `fmt_i` = 2'b01 (24-bit right-justified), `lrck_i` high marks left. The 24 bits ending with the last period before the frame clock toggles form the word, LSB last.
- R5: With `fmt_i` = 2'b00 (20-bit right-justified), `lrck_i` high marks left. The last 20 bits before the toggle form the word, and bit 19 is copied into bits 23..20. Periods 0..3 of the half have no effect.
- R6: `valid_o` is high for exactly one cycle, right after the rising edge that samples period 0 of the half following a completed right half. `left_o` and `right_o` change at that same edge.
- R7: `left_o` and `right_o` keep their values in every cycle in which `valid_o` is low.
- R8: A half that spans fewer than 24 bit periods produces no word. It also discards a pending left word, so its frame gives no pulse.
- R9: A half that spans more than 24 bit periods is discarded in the same way as a short one.
- R10: A right word gives a pulse only when the half just before it was a completed left word. The first half seen after reset, which has no observed start, is never completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all sampling on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lrck_i | input | 1 | Frame (word-select) clock |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Format select: 00 RJ20, 01 RJ24, 10 LJ24, 11 I2S |
| left_o | output | 24 | Left sample of the last complete frame |
| right_o | output | 24 | Right sample of the last complete frame |
| valid_o | output | 1 | One-cycle strobe per complete frame |

## Verification
Every result is due at the rising edge that first sees the frame clock at its new level: one register stage from that edge to the outputs. For I2S, that same edge also supplies the LSB. The bench's reference model advances on each rising edge from the values it drove on the preceding falling edge. It compares the expected strobe and both words against the ports on the falling edge. Every check therefore falls half a period after the edge that should have produced the result. Pulse-count checks are taken one time step after a half-frame's last bit has been driven, once all falling-edge bookkeeping has settled.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  typedef enum logic [1:0] {
    FMT_RJ20 = 2'b00,
    FMT_RJ24 = 2'b01,
    FMT_LJ24 = 2'b10,
    FMT_I2S  = 2'b11
  } fmt_e;
endpackage

// File: rtl/pcm_rx_framer.sv
module pcm_rx_framer #(
  parameter int HALF_BITS = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic lrck_i,
  output logic edge_o,
  output logic full_o,
  output logic side_o
);
  localparam int CNT_MAX = HALF_BITS + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             lrck_q;
  logic [CNT_W-1:0] cnt_q;

  // period 0 of a new half is the edge where the level first differs
  assign edge_o = lrck_i ^ lrck_q;
  assign full_o = edge_o && (cnt_q == CNT_W'(HALF_BITS));
  assign side_o = lrck_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lrck_q <= 1'b0;
      cnt_q  <= CNT_W'(CNT_MAX);
    end else begin
      lrck_q <= lrck_i;
      if (edge_o)
        cnt_q <= CNT_W'(1);
      else if (cnt_q != CNT_W'(CNT_MAX))
        cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(CNT_MAX));
endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift import pcm_rx_pkg::*; #(
  parameter int WORD_W  = 24,
  parameter int SHORT_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdata_i,
  input  fmt_e              fmt_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int PAD_W = WORD_W - SHORT_W;

  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= {sr_q[WORD_W-2:0], sdata_i};
  end

  always_comb begin
    case (fmt_i)
      FMT_I2S:  word_o = {sr_q[WORD_W-2:0], sdata_i};
      FMT_RJ20: word_o = {{PAD_W{sr_q[SHORT_W-1]}}, sr_q[SHORT_W-1:0]};
      default:  word_o = sr_q;
    endcase
  end
endmodule

// File: rtl/pcm_rx_pair.sv
module pcm_rx_pair #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              edge_i,
  input  logic              full_i,
  input  logic              is_left_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  logic [WORD_W-1:0] hold_q;
  logic              ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      ok_q    <= 1'b0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (edge_i) begin
        if (!full_i) begin
          ok_q <= 1'b0;
        end else if (is_left_i) begin
          hold_q <= word_i;
          ok_q   <= 1'b1;
        end else begin
          ok_q <= 1'b0;
          if (ok_q) begin
            left_o  <= hold_q;
            right_o <= word_i;
            valid_o <= 1'b1;
          end
        end
      end
    end
  end

  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx import pcm_rx_pkg::*; #(
  parameter int WORD_W    = 24,
  parameter int HALF_BITS = 24,
  parameter int SHORT_W   = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lrck_i,
  input  logic              sdata_i,
  input  logic [1:0]        fmt_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  fmt_e              fmt;
  logic              edge_w;
  logic              full_w;
  logic              side_w;
  logic              is_left;
  logic [WORD_W-1:0] word_w;

  assign fmt     = fmt_e'(fmt_i);
  // I2S flips the word-select polarity
  assign is_left = (fmt == FMT_I2S) ? ~side_w : side_w;

  pcm_rx_framer #(.HALF_BITS(HALF_BITS)) u_framer (
    .clk(clk), .rst(rst), .lrck_i(lrck_i),
    .edge_o(edge_w), .full_o(full_w), .side_o(side_w)
  );

  pcm_rx_shift #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_shift (
    .clk(clk), .rst(rst), .sdata_i(sdata_i), .fmt_i(fmt), .word_o(word_w)
  );

  pcm_rx_pair #(.WORD_W(WORD_W)) u_pair (
    .clk(clk), .rst(rst), .edge_i(edge_w), .full_i(full_w),
    .is_left_i(is_left), .word_i(word_w),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  // R6
  pulse_on_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ($past(lrck_i) != $past(lrck_i, 2)));

  // R5
  sign_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && $past(fmt_i) == 2'b00) |->
      (left_o == WORD_W'($signed(left_o[SHORT_W-1:0])) &&
       right_o == WORD_W'($signed(right_o[SHORT_W-1:0]))));
endmodule

// File: tb/test_pcm_serial_rx.sv
module test_pcm_serial_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lrck = 1'b0;
  logic        sdata = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  int checks = 0;
  int fails = 0;
  int npulse = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  pcm_serial_rx i_pcm_serial_rx (
    .clk(clk), .rst(rst), .lrck_i(lrck), .sdata_i(sdata), .fmt_i(fmt),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  function automatic string ftag(input logic [1:0] f);
    case (f)
      2'b00:   return "R5";
      2'b01:   return "R4";
      2'b10:   return "R2";
      default: return "R3";
    endcase
  endfunction

  // behavioural reference: queue of the bits seen in the current half
  bit          mq[$];
  bit          mprev = 1'b0;
  bit          mstarted = 1'b0;
  bit          mok = 1'b0;
  logic [23:0] mhold = '0;
  logic [23:0] el = '0, er = '0;
  bit          ev = 1'b0;

  always @(posedge clk) begin
    logic [23:0] w;
    bit          lft;
    ev = 1'b0;
    if (rst) begin
      mprev = 1'b0; mq.delete(); mstarted = 1'b0; mok = 1'b0;
      el = '0; er = '0;
    end else begin
      if (lrck != mprev) begin
        if (mstarted && mq.size() == 24) begin
          if (fmt == 2'b11) begin
            for (int k = 0; k < 23; k++) w[23-k] = mq[k+1];
            w[0] = sdata;
          end else begin
            for (int k = 0; k < 24; k++) w[23-k] = mq[k];
            if (fmt == 2'b00) w = {{4{w[19]}}, w[19:0]};
          end
          lft = (fmt == 2'b11) ? !mprev : mprev;
          if (lft) begin
            mhold = w; mok = 1'b1;
          end else begin
            if (mok) begin el = mhold; er = w; ev = 1'b1; end
            mok = 1'b0;
          end
        end else begin
          mok = 1'b0;
        end
        mq.delete();
        mstarted = 1'b1;
      end
      mq.push_back(sdata);
      if (mq.size() > 25) void'(mq.pop_front());
      mprev = lrck;
    end
  end

  // compare on every falling edge, half a period after the producing edge
  always @(negedge clk) begin
    cycles++;
    checks += 3;
    if (valid_o !== ev) begin
      fails++;
      $display("FAIL R6: valid_o got %0b exp %0b at cycle %0d", valid_o, ev, cycles);
    end
    if (left_o !== el) begin
      fails++;
      $display("FAIL %s: left_o got %h exp %h", ev ? ftag(fmt) : "R7", left_o, el);
    end
    if (right_o !== er) begin
      fails++;
      $display("FAIL %s: right_o got %h exp %h", ev ? ftag(fmt) : "R7", right_o, er);
    end
    if (valid_o === 1'b1) npulse++;
  end

  initial begin
    #(20 * 60000);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  function automatic bit bit_for(input logic [1:0] f, input logic [23:0] w,
                                 input int i, input logic [23:0] pw);
    if (f == 2'b11) return (i == 0) ? pw[0] : ((i < 24) ? w[24-i] : 1'b0);
    if (f == 2'b00) return (i < 4) ? 1'b1 : ((i < 24) ? w[23-i] : 1'b0);
    return (i < 24) ? w[23-i] : 1'b0;
  endfunction

  task automatic send_half(input bit lvl, input logic [23:0] w, input int n,
                           input logic [23:0] pw);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lrck  = lvl;
      sdata = bit_for(fmt, w, i, pw);
    end
  endtask

  task automatic check_int(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic check_word(input string tag, input logic [23:0] got,
                            input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [23:0] expect_word(input logic [1:0] f, input logic [23:0] w);
    return (f == 2'b00) ? {{4{w[19]}}, w[19:0]} : w;
  endfunction

  task automatic run_format(input logic [1:0] f);
    bit          lv, rv;
    logic [23:0] pw, wl, wr, last_l, last_r;
    @(negedge clk);
    rst = 1'b1; fmt = f; lrck = 1'b0; sdata = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check_word("R1", {23'd0, valid_o}, 24'd0);
    check_word("R1", left_o, 24'd0);
    check_word("R1", right_o, 24'd0);
    rst = 1'b0;
    npulse = 0;
    lv = (f == 2'b11) ? 1'b0 : 1'b1;
    rv = !lv;
    pw = '0;
    last_l = '0; last_r = '0;
    // R10: lead-in half has no observed start
    send_half(rv, 24'h0, 24, pw);
    for (int k = 0; k < 3; k++) begin
      wl = 24'($urandom); wr = 24'($urandom);
      send_half(lv, wl, 24, pw); pw = wl;
      send_half(rv, wr, 24, pw); pw = wr;
      last_l = wl; last_r = wr;
    end
    // R8: short left half
    wl = 24'($urandom);
    send_half(lv, wl, 10, pw); pw = wl;
    #1;
    check_int("R10", npulse, 3);
    wr = 24'($urandom);
    send_half(rv, wr, 24, pw); pw = wr;
    // R8: short right half
    wl = 24'($urandom); wr = 24'($urandom);
    send_half(lv, wl, 24, pw); pw = wl;
    send_half(rv, wr, 12, pw); pw = wr;
    // R9: long left half
    wl = 24'($urandom);
    send_half(lv, wl, 30, pw); pw = wl;
    #1;
    check_int("R8", npulse, 3);
    wr = 24'($urandom);
    send_half(rv, wr, 24, pw); pw = wr;
    for (int k = 0; k < 2; k++) begin
      wl = 24'($urandom); wr = 24'($urandom);
      send_half(lv, wl, 24, pw); pw = wl;
      send_half(rv, wr, 24, pw); pw = wr;
      last_l = wl; last_r = wr;
    end
    // trailing half carries the final I2S LSB, then idles (R7 hold)
    send_half(lv, 24'h0, 34, pw);
    #1;
    check_int("R9", npulse, 5);
    check_word(ftag(f), left_o, expect_word(f, last_l));
    check_word(ftag(f), right_o, expect_word(f, last_r));
    check_word("R7", {23'd0, valid_o}, 24'd0);
  endtask

  initial begin
    run_format(2'b10);
    run_format(2'b01);
    run_format(2'b00);
    run_format(2'b11);
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule